// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block moves 36-bit words from a write-clock domain to a read-clock domain that runs independently. The producer presents a word with a write enable and watches an input-ready flag and an active-low almost-full flag, both timed to the write clock. On the consumer side the oldest word appears by itself in a registered output, flagged by output-ready. A read enable pulse, given while output-ready is high, takes that word and lets the next one fall through. An active-low almost-empty flag, timed to the read clock, warns when few words remain.

Pointers cross between the domains as gray code through two-flop synchronizers. Each pointer is one bit wider than the memory address, so a full memory and an empty memory look different. The word held in the output register is not part of the memory fill level, and its memory slot is already free. The block therefore holds DEPTH words in memory plus one in the output register. Both flag thresholds are parameters, taken as the offsets from reset onward. A single synchronous active-high reset is sampled by both clocks.

Top module: `xclk_fwft_fifo`

## Requirements
- R1: While reset is held and after it is released, with no writes, in_rdy is 1, af_n is 1, out_rdy is 0 and ae_n is 0.
- R2: A word written into an empty FIFO reaches dout without any read, and out_rdy rises after the third rising read-clock edge that follows the write edge.
- R3: Words leave in the order written. A read taken while out_rdy is 1 replaces dout with the next stored word, or drops out_rdy when memory holds none.
- R4: in_rdy is 0 exactly when memory holds DEPTH words, not counting the output register. A write while in_rdy is 0 is ignored and stores nothing.
- R5: A read while out_rdy is 0 is ignored and consumes nothing, so the next word written is still delivered.
- R6: ae_n is 0 while memory holds AE_OFS or fewer words, and 1 while it holds AE_OFS+1 or more.
- R7: af_n is 0 while memory holds DEPTH-AF_OFS or more words, and 1 while it holds DEPTH-AF_OFS-1 or fewer.
- R8: After the write that brings memory to AE_OFS+1 words, ae_n stays 0 through the first rising read-clock edge and is 1 after the second.
- R9: After the read that brings memory down to DEPTH-AF_OFS-1 words, af_n stays 0 through the first rising write-clock edge and is 1 after the second.
- R10: While out_rdy is 1 and no read is given, dout and out_rdy hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wen | input | 1 | Write enable, taken on a wclk rising edge when in_rdy is 1 |
| din | input | DATA_W | Word to write |
| in_rdy | output | 1 | High while memory has a free slot (wclk domain) |
| af_n | output | 1 | Low while memory holds DEPTH-AF_OFS words or more (wclk domain) |
| ren | input | 1 | Read enable, taken on an rclk rising edge when out_rdy is 1 |
| dout | output | DATA_W | Registered output word |
| out_rdy | output | 1 | High while dout holds a valid word (rclk domain) |
| ae_n | output | 1 | Low while memory holds AE_OFS words or fewer (rclk domain) |

## Verification
Each result has its own delay. in_rdy falls just after the write edge that fills memory. ae_n rises after the second read-clock edge that follows the write, out_rdy and the fallen-through word after the third, and af_n after the second write-clock edge that follows the read. Both clocks run at the same rate with the read edges 5 ns after the write edges, so every one of these edges falls at a known time. The directed checks sample 5 ns before and 5 ns after the edge on which a change is due, and so catch both an early and a late flag. Level checks are made only after several idle cycles, once both synchronizers have settled. Every read is checked against the expected word at the falling edge before the rising edge that takes it.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    // Flag pair reported by each side of the FIFO.
    typedef struct packed {
        logic ready;   // slot free (write side) / word valid (read side)
        logic almost;  // active-low threshold flag
    } side_flags_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int W     = 36,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
    import fifo_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int AF_OFS = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wen,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output side_flags_t   flags
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] AF_CNT   = PW'(DEPTH - AF_OFS);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] fill;

    assign rbin_s       = PW'(from_gray(32'(rgray_s)));
    assign fill         = wbin - rbin_s;
    assign flags.ready  = (fill != FULL_CNT);
    assign flags.almost = (fill < AF_CNT);
    assign we           = wen && flags.ready;
    assign waddr        = wbin[AW-1:0];
    assign wbin_nxt     = wbin + PW'(1);

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nxt;
            wgray <= PW'(to_gray(32'(wbin_nxt)));
        end
    end

    // The write side never sees more than DEPTH words stored.
    assert_wr_fill_bound_R4: assert property (@(posedge wclk) disable iff (rst)
        fill <= FULL_CNT);

    // A write offered while no slot is free leaves the pointer alone.
    assert_ignored_write_R4: assert property (@(posedge wclk) disable iff (rst)
        (wen && !flags.ready) |=> (wbin == $past(wbin)));

    // The crossing pointer changes by at most one bit per edge.
    assert_wgray_step_R3: assert property (@(posedge wclk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_pkg::*;
#(
    parameter int W      = 36,
    parameter int DEPTH  = 512,
    parameter int AE_OFS = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          ren,
    input  logic [PW-1:0] wgray_s,
    input  logic [W-1:0]  rdata,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic [W-1:0]  dout,
    output side_flags_t   flags
);
    localparam logic [PW-1:0] AE_CNT   = PW'(AE_OFS);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] fill;
    logic          held;
    logic          load;

    assign wbin_s       = PW'(from_gray(32'(wgray_s)));
    assign fill         = wbin_s - rbin;
    assign load         = (fill != '0) && (!held || ren);
    assign raddr        = rbin[AW-1:0];
    assign rbin_nxt     = rbin + PW'(1);
    assign flags.ready  = held;
    assign flags.almost = (fill > AE_CNT);

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            held  <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            rbin  <= rbin_nxt;
            rgray <= PW'(to_gray(32'(rbin_nxt)));
            dout  <= rdata;
            held  <= 1'b1;
        end else if (ren) begin
            held  <= 1'b0;
        end
    end

    // With no read the presented word stays put.
    assert_hold_output_R10: assert property (@(posedge rclk) disable iff (rst)
        (held && !ren) |=> (held && $stable(dout)));

    // A read with nothing presented and nothing stored consumes nothing.
    assert_ignored_read_R5: assert property (@(posedge rclk) disable iff (rst)
        (!held && ren && fill == '0) |=> (!held && $stable(rbin)));

    // The read side never sees more than DEPTH words stored.
    assert_rd_fill_bound_R6: assert property (@(posedge rclk) disable iff (rst)
        fill <= FULL_CNT);

    // The crossing pointer changes by at most one bit per edge.
    assert_rgray_step_R3: assert property (@(posedge rclk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/xclk_fwft_fifo.sv
module xclk_fwft_fifo
    import fifo_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 512,
    parameter int AE_OFS = 8,
    parameter int AF_OFS = 8
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              wen,
    input  logic [DATA_W-1:0] din,
    output logic              in_rdy,
    output logic              af_n,
    input  logic              ren,
    output logic [DATA_W-1:0] dout,
    output logic              out_rdy,
    output logic              ae_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_in_r;
    logic [PW-1:0]     rgray_in_w;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic              we;
    logic [DATA_W-1:0] rdata;
    side_flags_t       wflags;
    side_flags_t       rflags;

    fifo_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .wclk (wclk),
        .we   (we),
        .waddr(waddr),
        .wdata(din),
        .raddr(raddr),
        .rdata(rdata)
    );

    fifo_sync #(.W(PW)) u_sync_w2r (
        .clk(rclk),
        .rst(rst),
        .d  (wgray),
        .q  (wgray_in_r)
    );

    fifo_sync #(.W(PW)) u_sync_r2w (
        .clk(wclk),
        .rst(rst),
        .d  (rgray),
        .q  (rgray_in_w)
    );

    fifo_wr_ctl #(.DEPTH(DEPTH), .AF_OFS(AF_OFS)) u_wr (
        .wclk   (wclk),
        .rst    (rst),
        .wen    (wen),
        .rgray_s(rgray_in_w),
        .wgray  (wgray),
        .waddr  (waddr),
        .we     (we),
        .flags  (wflags)
    );

    fifo_rd_ctl #(.W(DATA_W), .DEPTH(DEPTH), .AE_OFS(AE_OFS)) u_rd (
        .rclk   (rclk),
        .rst    (rst),
        .ren    (ren),
        .wgray_s(wgray_in_r),
        .rdata  (rdata),
        .rgray  (rgray),
        .raddr  (raddr),
        .dout   (dout),
        .flags  (rflags)
    );

    assign in_rdy  = wflags.ready;
    assign af_n    = wflags.almost;
    assign out_rdy = rflags.ready;
    assign ae_n    = rflags.almost;
endmodule

// File: tb/xclk_fwft_fifo_test.sv
module xclk_fwft_fifo_test;
    localparam int DATA_W = 36;
    localparam int DEPTH  = 512;
    localparam int AE_OFS = 8;
    localparam int AF_OFS = 8;

    logic              wclk = 1'b0;
    logic              rclk = 1'b0;
    logic              rst  = 1'b1;
    logic              wen  = 1'b0;
    logic [DATA_W-1:0] din  = '0;
    logic              ren  = 1'b0;
    logic              in_rdy, af_n, out_rdy, ae_n;
    logic [DATA_W-1:0] dout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [DATA_W-1:0] q[$];

    // 50 MHz on both sides; read edges trail write edges by 5 ns.
    initial forever #10 wclk = ~wclk;
    initial begin #5; forever #10 rclk = ~rclk; end

    xclk_fwft_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) uut (
        .wclk(wclk), .rclk(rclk), .rst(rst),
        .wen(wen), .din(din), .in_rdy(in_rdy), .af_n(af_n),
        .ren(ren), .dout(dout), .out_rdy(out_rdy), .ae_n(ae_n)
    );

    function automatic void chk_bit(string req, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endfunction

    function automatic void chk_word(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s dout: actual %h expected %h", req, act, exp);
        end
    endfunction

    function automatic logic [DATA_W-1:0] rnd_word();
        return {4'($urandom), $urandom};
    endfunction

    // Expected flags from the number of words held (memory plus output register).
    task automatic check_flags(input string req);
        int stored;
        int mem;
        repeat (8) @(negedge rclk);
        stored = q.size();
        mem    = (stored > 0) ? stored - 1 : 0;
        chk_bit(req, "out_rdy", out_rdy, stored > 0);
        chk_bit(req, "ae_n", ae_n, mem > AE_OFS);
        chk_bit(req, "af_n", af_n, mem < DEPTH - AF_OFS);
        chk_bit(req, "in_rdy", in_rdy, mem < DEPTH);
    endtask

    task automatic put(input logic [DATA_W-1:0] d);
        bit acc;
        @(negedge wclk);
        wen = 1'b1;
        din = d;
        acc = in_rdy;
        @(negedge wclk);
        wen = 1'b0;
        if (acc) q.push_back(d);
    endtask

    task automatic get(input string req);
        @(negedge rclk);
        ren = 1'b1;
        if (out_rdy) begin
            if (q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL %s dout: actual %h expected no word", req, dout);
            end else begin
                chk_word(req, dout, q[0]);
                void'(q.pop_front());
            end
        end
        @(negedge rclk);
        ren = 1'b0;
    endtask

    task automatic drain(input string req);
        int guard = 0;
        while (q.size() > 0 && guard < 4000) begin
            get(req);
            guard++;
        end
    endtask

    initial begin
        logic [DATA_W-1:0] w;
        void'($urandom(32'd2024));

        // R1: reset state, during and after reset
        repeat (5) @(negedge wclk);
        chk_bit("R1", "in_rdy in reset", in_rdy, 1'b1);
        chk_bit("R1", "out_rdy in reset", out_rdy, 1'b0);
        rst = 1'b0;
        check_flags("R1");

        // R2: first word falls through; out_rdy on the third read edge
        w = rnd_word();
        @(negedge wclk);
        wen = 1'b1;
        din = w;
        @(posedge wclk);
        q.push_back(w);
        #10 wen = 1'b0;
        #30 chk_bit("R2", "out_rdy before third edge", out_rdy, 1'b0);
        #10 chk_bit("R2", "out_rdy after third edge", out_rdy, 1'b1);
        chk_word("R2", dout, w);

        // R10: no read, word held
        repeat (10) @(negedge rclk);
        chk_bit("R10", "out_rdy held", out_rdy, 1'b1);
        chk_word("R10", dout, w);

        // R6: memory at AE_OFS words keeps ae_n low
        for (int i = 0; i < AE_OFS; i++) put(rnd_word());
        check_flags("R6");

        // R8: write to AE_OFS+1 words, ae_n rises after the second read edge
        w = rnd_word();
        @(negedge wclk);
        wen = 1'b1;
        din = w;
        @(posedge wclk);
        q.push_back(w);
        #10 wen = 1'b0;
        #10 chk_bit("R8", "ae_n before second edge", ae_n, 1'b0);
        #10 chk_bit("R8", "ae_n after second edge", ae_n, 1'b1);
        check_flags("R6");

        // R3/R6: one read brings memory back to AE_OFS
        get("R3");
        check_flags("R6");

        // R4/R7: fill memory to DEPTH words
        while (q.size() < DEPTH + 1) put(rnd_word());
        check_flags("R4");
        put(36'hBAD_0BAD_0);     // offered while full: must be dropped
        check_flags("R4");

        // R7: read down to DEPTH-AF_OFS words, af_n still low
        for (int i = 0; i < AF_OFS; i++) get("R3");
        check_flags("R7");

        // R9: read to DEPTH-AF_OFS-1, af_n rises after the second write edge
        @(negedge rclk);
        ren = 1'b1;
        chk_word("R3", dout, q[0]);
        void'(q.pop_front());
        @(posedge rclk);
        #10 ren = 1'b0;
        #20 chk_bit("R9", "af_n before second edge", af_n, 1'b0);
        #10 chk_bit("R9", "af_n after second edge", af_n, 1'b1);
        check_flags("R7");

        // R3/R4: drain everything; the dropped word must not appear
        drain("R3");
        check_flags("R4");

        // R5: reads with nothing held are ignored
        for (int i = 0; i < 6; i++) get("R5");
        check_flags("R5");
        w = rnd_word();
        put(w);
        check_flags("R5");
        chk_word("R5", dout, w);
        get("R5");

        // R3: random traffic on both sides
        fork
            begin
                for (int i = 0; i < 3000; i++) begin
                    @(negedge wclk);
                    wen = ($urandom % 4) != 0;
                    din = rnd_word();
                    if (wen && in_rdy) q.push_back(din);
                end
                @(negedge wclk);
                wen = 1'b0;
            end
            begin
                for (int i = 0; i < 3000; i++) begin
                    @(negedge rclk);
                    ren = ($urandom % 3) == 0;
                    if (ren && out_rdy) begin
                        if (q.size() == 0) begin
                            n_cmp++; n_bad++;
                            $display("FAIL R3 dout: actual %h expected no word", dout);
                        end else begin
                            chk_word("R3", dout, q[0]);
                            void'(q.pop_front());
                        end
                    end
                end
                @(negedge rclk);
                ren = 1'b0;
            end
        join
        check_flags("R3");
        drain("R3");
        check_flags("R3");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule